// File: doc/BRIEF.md
# External bus request splitter

The splitter sits between an internal master and a narrow external data port. It takes one internal request of 4, 8 or 32 bytes, either read or write. It then issues the series of external transactions needed to move that request over a port 16 or 32 bits wide. The shape of the series is fixed when the request is accepted. It depends on three things: whether the target bank allows bursts (a non chip-select access never does), the bank's port width, and a global flag that says the external data bus is only 16 bits wide.

Each external transaction opens with a one-cycle `ext_start` strobe. That strobe carries the address, a burst flag and a beat count. The target then acknowledges every beat with `ext_ack`. Acknowledges in the start cycle itself are not counted. For reads, the splitter places each beat's bytes into an assembly register. For writes, it drives the right slice of the latched write data for each beat. When the last beat is acknowledged, the splitter raises a single `done` pulse. Byte k of a request, counting from the lowest address, always sits at `req_wdata`/`rd_data` bits [255-8k -: 8]. On the external bus the lowest-addressed byte of a beat sits on bits [31:24]. A 16-bit port uses bits [31:16] only.

Top module: `ext_req_splitter`

## Requirements
- R1: With `bank_no_burst`=1 and `bus_mode16`=0, a 4-byte request (`req_size`=0) to a 16-bit port (`bank_port16`=1) becomes two single-beat transactions (`ext_burst`=0, `ext_beats`=1).
- R2: With `bus_mode16`=1, that same inhibited 4-byte request to a 16-bit port becomes one transaction with `ext_burst`=1 and `ext_beats`=2.
- R3: With bursting inhibited, an 8-byte request (`req_size`=1) becomes 2 single-beat transactions on a 32-bit port and 4 on a 16-bit port.
- R4: With bursting inhibited, a 32-byte request (`req_size`=2) becomes 8 single-beat transactions on a 32-bit port and 16 on a 16-bit port.
- R5: For a burstable bank (`bank_cs_hit`=1, `bank_no_burst`=0), a 32-byte request becomes two bursts, of 4 beats on a 32-bit port or 8 beats on a 16-bit port. A smaller request becomes one transaction whose beat count is the byte count divided by the port width, with `ext_burst`=1 only when that count exceeds 1.
- R6: Unless R7 applies, the next transaction's `ext_start` comes in the cycle right after the acknowledge that ends the previous transaction.
- R7: For a write of more than 8 bytes, exactly `WR_GAP` idle cycles (default 1) separate the final acknowledge of one transaction from the next `ext_start`.
- R8: Read bytes land in `rd_data` using the byte mapping above. `rd_data` is cleared when a request is accepted and holds its value after `done`.
- R9: During each beat, `ext_wdata` carries that beat's request bytes using the same lane mapping, with bits [15:0] zero on a 16-bit port. It stays stable until the beat is acknowledged.
- R10: `req_ready` is high only when idle, and a request presented while busy is ignored and not queued. `done` is a one-cycle pulse in the cycle after the final acknowledge, and `req_ready` is high in that same cycle.
- R11: An access with `bank_cs_hit`=0 is split as if bursting were inhibited, whatever the value of `bank_no_burst`.
- R12: The address of each beat equals the request address plus the bytes already moved, so each `ext_start` presents the first unmoved byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Splitter idle; request accepted when valid |
| req_addr | input | 32 | Request start address |
| req_size | input | 2 | 0 = 4 bytes, 1 = 8 bytes, 2 = 32 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 256 | Write data, byte k at [255-8k -: 8] |
| bank_no_burst | input | 1 | Target bank forbids bursts |
| bank_cs_hit | input | 1 | Access decodes to a chip-select bank |
| bank_port16 | input | 1 | Bank port is 16 bits (else 32) |
| bus_mode16 | input | 1 | External data bus runs 16 bits wide |
| ext_start | output | 1 | First cycle of an external transaction |
| ext_addr | output | 32 | Address of the current beat |
| ext_burst | output | 1 | Transaction is a burst |
| ext_beats | output | 4 | Beats in this transaction |
| ext_write | output | 1 | Transaction direction |
| ext_wdata | output | 32 | Write data of the current beat |
| ext_ack | input | 1 | Beat acknowledge |
| ext_rdata | input | 32 | Read data of the acknowledged beat |
| done | output | 1 | One-cycle completion of the internal request |
| rd_data | output | 256 | Assembled read data |

## Verification
The assertions assume that the target acknowledges exactly the number of beats announced with each `ext_start` and never in the start cycle. They also assume that `req_size` never carries the spare code 3, and that bank attributes matter only in the accept cycle. The bench's responder model counts the beats out of `ext_beats` and waits a fixed latency before each acknowledge, so it stays within these limits. It only drives size codes 0 to 2. A stray request pulse is driven during a busy period to show it is dropped.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic [1:0] {
      SZ_4B   = 2'd0,
      SZ_8B   = 2'd1,
      SZ_32B  = 2'd2,
      SZ_SPARE = 2'd3
   } req_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_DATA,
      ST_GAP
   } seq_state_e;

   // Byte count of a size code; the spare code behaves as a 4-byte request.
   function automatic logic [5:0] size_to_bytes(input req_size_e s);
      case (s)
         SZ_8B:   return 6'd8;
         SZ_32B:  return 6'd32;
         default: return 6'd4;
      endcase
   endfunction

endpackage

// File: rtl/xs_plan.sv
module xs_plan
   import xs_pkg::*;
#(
   parameter int PORT_W      = 32,
   parameter int BURST_BYTES = 16,
   parameter int TOT_W       = 6,
   parameter int BEAT_W      = 4
) (
   input  req_size_e          size,
   input  logic               no_burst,
   input  logic               cs_hit,
   input  logic               port16,
   input  logic               mode16,
   output logic [TOT_W-1:0]   total,
   output logic [BEAT_W-1:0]  beats
);

   localparam int WIDE_B   = PORT_W / 8;
   localparam int NARROW_B = PORT_W / 16;
   localparam int WIDE_SH   = $clog2(WIDE_B);
   localparam int NARROW_SH = $clog2(NARROW_B);

   logic [TOT_W-1:0] sub_bytes;
   logic             burstable;

   always_comb begin
      total     = TOT_W'(size_to_bytes(size));
      burstable = cs_hit && !no_burst;
      sub_bytes = (total > TOT_W'(BURST_BYTES)) ? TOT_W'(BURST_BYTES) : total;
      if (burstable) begin
         beats = port16 ? BEAT_W'(sub_bytes >> NARROW_SH)
                        : BEAT_W'(sub_bytes >> WIDE_SH);
      end else if (port16 && mode16 && total == TOT_W'(2 * NARROW_B)) begin
         beats = BEAT_W'(2);   // folded into one short burst
      end else begin
         beats = BEAT_W'(1);
      end
   end

endmodule

// File: rtl/xs_seq.sv
module xs_seq
   import xs_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int PORT_W       = 32,
   parameter int TOT_W        = 6,
   parameter int BEAT_W       = 4,
   parameter int WR_GAP       = 1,
   parameter int BIG_WR_BYTES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [TOT_W-1:0]   plan_total,
   input  logic [BEAT_W-1:0]  plan_beats,
   input  logic               port16,
   input  logic               ext_ack,
   output logic               req_ready,
   output logic               accept,
   output logic               ext_start,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic               ext_burst,
   output logic [BEAT_W-1:0]  ext_beats,
   output logic               ext_write,
   output logic               in_data,
   output logic               port16_q,
   output logic [TOT_W-1:0]   cursor,
   output logic               done
);

   seq_state_e        state;
   logic [ADDR_W-1:0] base_q;
   logic [TOT_W-1:0]  total_q;
   logic [BEAT_W-1:0] beats_q;
   logic [BEAT_W-1:0] bcnt;
   logic              wr_q;
   logic              done_q;

   logic [TOT_W-1:0]  step;
   logic              take;
   logic              last_beat;
   logic              final_sub;
   logic              big_wr;
   logic              need_gap;
   logic              gap_over;

   always_comb begin
      step      = port16_q ? TOT_W'(PORT_W / 16) : TOT_W'(PORT_W / 8);
      take      = (state == ST_DATA) && ext_ack;
      last_beat = (bcnt == beats_q - BEAT_W'(1));
      final_sub = (cursor + step == total_q);
      big_wr    = wr_q && (total_q > TOT_W'(BIG_WR_BYTES));
   end

   generate
      if (WR_GAP > 0) begin : g_gap
         localparam int GAP_W = $clog2(WR_GAP + 1);
         logic [GAP_W-1:0] gap_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_cnt <= '0;
            end else if (take && last_beat && !final_sub && big_wr) begin
               gap_cnt <= GAP_W'(WR_GAP);
            end else if (state == ST_GAP) begin
               gap_cnt <= gap_cnt - GAP_W'(1);
            end
         end

         assign need_gap = big_wr;
         assign gap_over = (gap_cnt == GAP_W'(1));

         // R7: a long write leaves the bus idle right after a sub-transaction ends
         a_r7_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (take && last_beat && !final_sub && big_wr) |=> !ext_start);
      end else begin : g_nogap
         assign need_gap = 1'b0;
         assign gap_over = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         base_q   <= '0;
         total_q  <= '0;
         beats_q  <= '0;
         bcnt     <= '0;
         wr_q     <= 1'b0;
         port16_q <= 1'b0;
         cursor   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  base_q   <= req_addr;
                  total_q  <= plan_total;
                  beats_q  <= plan_beats;
                  wr_q     <= req_write;
                  port16_q <= port16;
                  cursor   <= '0;
                  state    <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               bcnt  <= '0;
               state <= ST_DATA;
            end
            ST_DATA: begin
               if (take) begin
                  cursor <= cursor + step;
                  bcnt   <= bcnt + BEAT_W'(1);
                  if (last_beat) begin
                     if (final_sub) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                     end else if (need_gap) begin
                        state <= ST_GAP;
                     end else begin
                        state <= ST_ISSUE;
                     end
                  end
               end
            end
            default: begin
               if (gap_over) state <= ST_ISSUE;
            end
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign ext_start = (state == ST_ISSUE);
   assign in_data   = (state == ST_DATA);
   assign ext_addr  = base_q + ADDR_W'(cursor);
   assign ext_burst = (beats_q > BEAT_W'(1));
   assign ext_beats = beats_q;
   assign ext_write = wr_q;
   assign done      = done_q;

   // R6: with no write gap, the following sub-transaction opens at once
   a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_beat && !final_sub && !big_wr) |=> ext_start);

   // R10: the final acknowledge produces completion and a ready splitter
   a_r10_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_beat && final_sub) |=> (done && req_ready));

   // R10: completion is a single-cycle pulse
   a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an accepted request opens its first transaction next cycle
   a_r10_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ext_start);

   // R5: every transaction carries a power-of-two beat count
   a_r5_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
      ext_start |-> ($countones(ext_beats) == 1));

endmodule

// File: rtl/xs_lanes.sv
module xs_lanes #(
   parameter int PORT_W    = 32,
   parameter int MAX_BYTES = 32,
   parameter int TOT_W     = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept,
   input  logic [8*MAX_BYTES-1:0]   req_wdata,
   input  logic                     take,
   input  logic                     port16_q,
   input  logic [TOT_W-1:0]         cursor,
   input  logic [PORT_W-1:0]        ext_rdata,
   output logic [PORT_W-1:0]        ext_wdata,
   output logic [8*MAX_BYTES-1:0]   rd_data
);

   localparam int DW     = 8 * MAX_BYTES;
   localparam int LANES  = PORT_W / 8;
   localparam int LIDX_W = $clog2(LANES);
   localparam int BIDX_W = $clog2(MAX_BYTES);

   logic [DW-1:0]    wbuf;
   logic [7:0]       wbytes [MAX_BYTES];
   logic [7:0]       rbytes [LANES];
   logic [TOT_W-1:0] step;

   assign step = port16_q ? TOT_W'(LANES / 2) : TOT_W'(LANES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wbuf <= '0;
      else if (accept) wbuf <= req_wdata;
   end

   generate
      for (genvar b = 0; b < MAX_BYTES; b++) begin : g_wbyte
         assign wbytes[b] = wbuf[DW-1-8*b -: 8];
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [TOT_W-1:0] src;
         logic             live;
         assign rbytes[l] = ext_rdata[PORT_W-1-8*l -: 8];
         assign src  = cursor + TOT_W'(l);
         assign live = (l < LANES / 2 || !port16_q) && (src < TOT_W'(MAX_BYTES));
         assign ext_wdata[PORT_W-1-8*l -: 8] = live ? wbytes[src[BIDX_W-1:0]] : 8'h00;
      end

      for (genvar j = 0; j < MAX_BYTES; j++) begin : g_rbyte
         logic [TOT_W-1:0] lane;
         logic             hit;
         logic [7:0]       q;
         assign lane = TOT_W'(j) - cursor;
         assign hit  = take && (TOT_W'(j) >= cursor) && (lane < step);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 8'h00;
            else if (accept) q <= 8'h00;
            else if (hit)    q <= rbytes[lane[LIDX_W-1:0]];
         end
         assign rd_data[DW-1-8*j -: 8] = q;
      end
   endgenerate

   // R8: accepting a request empties the assembly register
   a_r8_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rd_data == '0));

endmodule

// File: rtl/ext_req_splitter.sv
module ext_req_splitter
   import xs_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PORT_W      = 32,
   parameter int MAX_BYTES   = 32,
   parameter int BURST_BYTES = 16,
   parameter int WR_GAP      = 1,
   localparam int DW     = 8 * MAX_BYTES,
   localparam int TOT_W  = $clog2(MAX_BYTES + 1),
   localparam int BEAT_W = $clog2(BURST_BYTES / (PORT_W / 16) + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [1:0]         req_size,
   input  logic               req_write,
   input  logic [DW-1:0]      req_wdata,
   input  logic               bank_no_burst,
   input  logic               bank_cs_hit,
   input  logic               bank_port16,
   input  logic               bus_mode16,
   output logic               ext_start,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic               ext_burst,
   output logic [BEAT_W-1:0]  ext_beats,
   output logic               ext_write,
   output logic [PORT_W-1:0]  ext_wdata,
   input  logic               ext_ack,
   input  logic [PORT_W-1:0]  ext_rdata,
   output logic               done,
   output logic [DW-1:0]      rd_data
);

   if (PORT_W != 32) begin : g_bad_port
      $error("PORT_W must be 32: the narrow mode uses its upper half");
   end
   if (MAX_BYTES != 32) begin : g_bad_max
      $error("MAX_BYTES must match the largest size code (32)");
   end
   if (BURST_BYTES < PORT_W / 8 || BURST_BYTES > MAX_BYTES ||
       (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_bad_burst
      $error("BURST_BYTES must be a power of two between the port width and MAX_BYTES");
   end
   if (WR_GAP < 0 || WR_GAP > 15) begin : g_bad_gap
      $error("WR_GAP out of range");
   end

   logic [TOT_W-1:0]  plan_total;
   logic [BEAT_W-1:0] plan_beats;
   logic              accept;
   logic              in_data;
   logic              port16_q;
   logic [TOT_W-1:0]  cursor;
   logic              take;

   xs_plan #(
      .PORT_W      (PORT_W),
      .BURST_BYTES (BURST_BYTES),
      .TOT_W       (TOT_W),
      .BEAT_W      (BEAT_W)
   ) u_plan (
      .size     (req_size_e'(req_size)),
      .no_burst (bank_no_burst),
      .cs_hit   (bank_cs_hit),
      .port16   (bank_port16),
      .mode16   (bus_mode16),
      .total    (plan_total),
      .beats    (plan_beats)
   );

   xs_seq #(
      .ADDR_W       (ADDR_W),
      .PORT_W       (PORT_W),
      .TOT_W        (TOT_W),
      .BEAT_W       (BEAT_W),
      .WR_GAP       (WR_GAP),
      .BIG_WR_BYTES (8)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .plan_total (plan_total),
      .plan_beats (plan_beats),
      .port16     (bank_port16),
      .ext_ack    (ext_ack),
      .req_ready  (req_ready),
      .accept     (accept),
      .ext_start  (ext_start),
      .ext_addr   (ext_addr),
      .ext_burst  (ext_burst),
      .ext_beats  (ext_beats),
      .ext_write  (ext_write),
      .in_data    (in_data),
      .port16_q   (port16_q),
      .cursor     (cursor),
      .done       (done)
   );

   assign take = in_data && ext_ack;

   xs_lanes #(
      .PORT_W    (PORT_W),
      .MAX_BYTES (MAX_BYTES),
      .TOT_W     (TOT_W)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_wdata (req_wdata),
      .take      (take),
      .port16_q  (port16_q),
      .cursor    (cursor),
      .ext_rdata (ext_rdata),
      .ext_wdata (ext_wdata),
      .rd_data   (rd_data)
   );

   // R9: write data holds while a beat waits for its acknowledge
   a_r9_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !ext_ack) |=> $stable(ext_wdata));

   // R12: address moves only on an acknowledged beat
   a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !ext_ack) |=> $stable(ext_addr));

endmodule

// File: tb/ext_req_splitter_test.sv
module ext_req_splitter_test;

   localparam int WR_GAP = 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [31:0]  req_addr = '0;
   logic [1:0]   req_size = '0;
   logic         req_write = 1'b0;
   logic [255:0] req_wdata = '0;
   logic         bank_no_burst = 1'b0;
   logic         bank_cs_hit = 1'b0;
   logic         bank_port16 = 1'b0;
   logic         bus_mode16 = 1'b0;
   logic         ext_start;
   logic [31:0]  ext_addr;
   logic         ext_burst;
   logic [3:0]   ext_beats;
   logic         ext_write;
   logic [31:0]  ext_wdata;
   logic         ext_ack = 1'b0;
   logic [31:0]  ext_rdata = '0;
   logic         done;
   logic [255:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   ext_req_splitter #(.WR_GAP(WR_GAP)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .bank_no_burst(bank_no_burst), .bank_cs_hit(bank_cs_hit),
      .bank_port16(bank_port16), .bus_mode16(bus_mode16),
      .ext_start(ext_start), .ext_addr(ext_addr), .ext_burst(ext_burst),
      .ext_beats(ext_beats), .ext_write(ext_write), .ext_wdata(ext_wdata),
      .ext_ack(ext_ack), .ext_rdata(ext_rdata),
      .done(done), .rd_data(rd_data)
   );

   // observation log of one request
   logic [31:0]  st_addr  [32];
   logic         st_burst [32];
   int           st_beats [32];
   int           st_cyc   [32];
   logic [31:0]  bt_addr  [32];
   logic [31:0]  bt_wd    [32];
   int           bt_cyc   [32];
   int           n_st, n_bt, done_cyc;
   logic [255:0] rd_cap;
   bit           late_start;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   function automatic logic [7:0] wbyte(input logic [255:0] w, input int k);
      return w[255-8*k -: 8];
   endfunction

   // drive one request, act as the external target, then check everything
   task automatic run(input string rq, input logic [1:0] sz, input bit wr,
                      input bit p16, input bit nob, input bit cs, input bit m16,
                      input logic [31:0] a, input int dly, input bit poke,
                      input logic [7:0] seed);
      int tb, pb, bps, nsub, left, wt, cyc, gap_exp;
      bit fin;
      logic [255:0] wd, exp_rd;
      tb = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 32;
      pb = p16 ? 2 : 4;
      wd = '0;
      for (int k = 0; k < 32; k++) wd[255-8*k -: 8] = 8'(k * 29) + seed;

      @(negedge clk);
      req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
      bank_port16 = p16; bank_no_burst = nob; bank_cs_hit = cs; bus_mode16 = m16;
      chk(req_ready == 1'b1, "R10", "ready before request", 256'(req_ready), 256'(1));
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10", "ready while busy", 256'(req_ready), 256'(0));

      n_st = 0; n_bt = 0; done_cyc = -1; left = 0; wt = 0; cyc = 0; fin = 0;
      late_start = 0;
      for (int it = 0; it < 400 && !fin; it++) begin
         ext_ack = 1'b0;
         req_valid = poke && (cyc == 3);
         if (poke && cyc == 3) req_addr = a + 32'h100;
         if (done) begin
            done_cyc = cyc;
            rd_cap = rd_data;
            fin = 1;
         end else if (ext_start) begin
            if (n_st < 32) begin
               st_addr[n_st] = ext_addr; st_burst[n_st] = ext_burst;
               st_beats[n_st] = int'(ext_beats); st_cyc[n_st] = cyc;
            end
            n_st++;
            left = int'(ext_beats); wt = dly;
         end else if (left > 0) begin
            if (wt > 0) wt--;
            else begin
               ext_ack = 1'b1;
               ext_rdata = p16 ? {mbyte(ext_addr), mbyte(ext_addr + 1), 16'h0000}
                               : {mbyte(ext_addr), mbyte(ext_addr + 1),
                                  mbyte(ext_addr + 2), mbyte(ext_addr + 3)};
               if (n_bt < 32) begin
                  bt_addr[n_bt] = ext_addr; bt_wd[n_bt] = ext_wdata; bt_cyc[n_bt] = cyc;
               end
               n_bt++; left--; wt = dly;
            end
         end
         if (!fin) begin
            cyc++;
            @(negedge clk);
         end
      end
      ext_ack = 1'b0;
      req_valid = 1'b0;
      chk(fin, "R10", "completion seen", 256'(fin), 256'(1));
      chk(req_ready == 1'b1, "R10", "ready with done", 256'(req_ready), 256'(1));
      for (int q = 0; q < 4; q++) begin
         @(negedge clk);
         if (ext_start || done) late_start = 1;
      end
      chk(!late_start, "R10", "no activity after completion", 256'(late_start), 256'(0));

      // expected shape of the series, from the requirements
      if (cs && !nob) begin
         bps = ((tb > 16) ? 16 : tb) / pb;
         nsub = tb / (bps * pb);
      end else if (p16 && m16 && tb == 4) begin
         bps = 2; nsub = 1;
      end else begin
         bps = 1; nsub = tb / pb;
      end
      gap_exp = (wr && tb > 8) ? 1 + WR_GAP : 1;

      chk(n_st == nsub, rq, "transaction count", 256'(n_st), 256'(nsub));
      chk(n_bt == tb / pb, rq, "beat count", 256'(n_bt), 256'(tb / pb));
      if (n_st == nsub && n_bt == tb / pb) begin
         for (int s = 0; s < nsub; s++) begin
            chk(st_beats[s] == bps, rq, "beats per transaction", 256'(st_beats[s]), 256'(bps));
            chk(st_burst[s] == (bps > 1), rq, "burst flag", 256'(st_burst[s]), 256'(bps > 1));
            chk(st_addr[s] == a + 32'(s * bps * pb), "R12", "start address",
                256'(st_addr[s]), 256'(a + 32'(s * bps * pb)));
            if (s > 0)
               chk(st_cyc[s] - bt_cyc[s*bps-1] == gap_exp, (gap_exp > 1) ? "R7" : "R6",
                   "spacing after last ack", 256'(st_cyc[s] - bt_cyc[s*bps-1]), 256'(gap_exp));
         end
         for (int i = 0; i < n_bt; i++) begin
            logic [31:0] ew;
            chk(bt_addr[i] == a + 32'(i * pb), "R12", "beat address",
                256'(bt_addr[i]), 256'(a + 32'(i * pb)));
            if (wr) begin
               ew = p16 ? {wbyte(wd, i*pb), wbyte(wd, i*pb+1), 16'h0000}
                        : {wbyte(wd, i*pb), wbyte(wd, i*pb+1),
                           wbyte(wd, i*pb+2), wbyte(wd, i*pb+3)};
               chk(bt_wd[i] == ew, "R9", "beat write data", 256'(bt_wd[i]), 256'(ew));
            end
         end
         chk(done_cyc == bt_cyc[n_bt-1] + 1, "R10", "done timing",
             256'(done_cyc), 256'(bt_cyc[n_bt-1] + 1));
      end
      if (!wr) begin
         exp_rd = '0;
         for (int k = 0; k < tb; k++) exp_rd[255-8*k -: 8] = mbyte(a + 32'(k));
         chk(rd_cap == exp_rd, "R8", "assembled read data", rd_cap, exp_rd);
         chk(rd_data == exp_rd, "R8", "read data held", rd_data, exp_rd);
      end
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R10", "ready after reset", 256'(req_ready), 256'(1));
      chk(ext_start == 1'b0, "R10", "no start after reset", 256'(ext_start), 256'(0));
      chk(done == 1'b0, "R10", "no done after reset", 256'(done), 256'(0));
      chk(rd_data == '0, "R8", "read data after reset", rd_data, '0);
   endtask

   task automatic t_split4_p16();     // R1
      run("R1", 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h1000_0040, 0, 1'b0, 8'h11);
   endtask

   task automatic t_fold4_mode16();   // R2
      run("R2", 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h2000_0010, 1, 1'b0, 8'h22);
   endtask

   task automatic t_write8_p32();     // R3, R9, R6
      run("R3", 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h3000_0080, 0, 1'b0, 8'h33);
   endtask

   task automatic t_read8_p16();      // R3 with acknowledge latency
      run("R3", 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h3000_00C8, 2, 1'b0, 8'h44);
   endtask

   task automatic t_read32_p32();     // R4
      run("R4", 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h4000_0020, 0, 1'b0, 8'h55);
   endtask

   task automatic t_write32_p16();    // R4, R7
      run("R4", 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h4000_0060, 0, 1'b0, 8'h66);
   endtask

   task automatic t_burst32_p32();    // R5
      run("R5", 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h5000_0000, 1, 1'b0, 8'h77);
   endtask

   task automatic t_burst32_write_p16();  // R5, R7
      run("R5", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h5000_0040, 0, 1'b0, 8'h88);
   endtask

   task automatic t_burst8_p32();     // R5 small burstable request
      run("R5", 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h5000_00A0, 0, 1'b0, 8'h99);
   endtask

   task automatic t_noncs_busy_poke();  // R11 and R10 stray request
      run("R11", 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h6000_0000, 0, 1'b1, 8'hAA);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_split4_p16();
      t_fold4_mode16();
      t_write8_p32();
      t_read8_p16();
      t_read32_p32();
      t_write32_p16();
      t_burst32_p32();
      t_burst32_write_p16();
      t_burst8_p32();
      t_noncs_busy_poke();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule